// File: doc/BRIEF.md
# Serial Memory Two-Wire Slave Engine

This block is the bus-facing controller of a byte-addressed serial memory. It oversamples the two-wire bus clock and data lines with a fast system clock. It recognises START, repeated START and STOP. It decodes a select byte made of a fixed type code and three strap-matched bits, then runs the byte-write, page-write, current-address-read, random-read and sequential-read sequences. It drives the data line only through an open-drain enable.

On the memory side it presents one address and either a write strobe with a data byte or a read data input. After a completed write sequence it raises a one-cycle commit request. While the memory reports busy, the engine stays off the bus. A master can therefore poll for the end of the write cycle by repeating START plus select until it sees an acknowledge. A write-control input blocks all data writes but leaves addressing and reads intact.

Top module: `sermem_i2c_slave`

## Requirements
- R1: After reset, sda_oe, mem_we and commit_req are low.
- R2: A select byte whose upper nibble is 1010 and whose bits 3:1 equal strap_i[2:0] is acknowledged in the 9th clock, with bit 0 = 1 meaning read. Any other select byte is not acknowledged, and the engine then ignores the bus until the next START.
- R3: After a write select, two address bytes, high byte first, are each acknowledged. The low ADDR_W bits of the 16-bit value become the current address.
- R4: With wc_i low, each data byte is acknowledged and produces one single-cycle mem_we pulse, with mem_addr at the current address and mem_wdata at the byte.
- R5: During writes, only the lower PAGE_W address bits advance, so a page wraps onto its own first byte.
- R6: With wc_i high, select and address bytes are still acknowledged, but every data byte is not acknowledged, mem_we stays low and the current address does not move.
- R7: A STOP in the bit slot right after an acknowledged data byte raises commit_req for one cycle. A STOP with no accepted data, or a STOP inside a byte, raises none.
- R8: A write select with an address and no STOP, then a repeated START and a read select, returns the byte at that address, MSB first.
- R9: Each byte read advances the address by one over the full ADDR_W range, wrapping from the last address to 0. A current-address read starts at the counter, and a master ACK yields the next byte.
- R10: After a master NACK on a read byte, the engine releases the data line and drives nothing until the next START.
- R11: While mem_busy is high, no select byte is acknowledged and the data line is never driven.
- R12: Reads return the same data whether wc_i is high or low.
- R13: sda_oe changes only while the synchronized bus clock is low.
- R14: A START seen inside a byte abandons that byte, and the following select byte is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| strap_i | input | 3 | Strap bits matched against select bits 3:1 |
| wc_i | input | 1 | Write control: 1 blocks data writes |
| mem_addr | output | ADDR_W | Current memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_rdata | input | 8 | Byte stored at mem_addr |
| commit_req | output | 1 | One-cycle request to start the internal write cycle |
| mem_busy | input | 1 | Internal write cycle in progress |

## Verification
Two things can fall on the same bus event. The rising clock edge that begins a STOP is also shifted in as a data bit, and the commit decision must still see the STOP as landing in the slot right after the data acknowledge. The bench ends byte writes, page writes, a write-protected byte, an address-only sequence and a half-sent byte with STOP. The monitor counts commit pulses against the two sequences that deserve one. The second case is a select byte that arrives while the busy window opened by that commit is still running. The bench polls straight after the STOP, expects no acknowledge, then waits for busy to fall and expects the same select to be acknowledged.

// File: rtl/sermem_i2c_pkg.sv
// Package: shared types and constants of the serial memory slave engine.
// Assumes: one select code type nibble, fixed by the bus convention.
package sermem_i2c_pkg;

    // Fixed type nibble that a select byte must carry in bits 7:4.
    localparam logic [3:0] SEL_TYPE = 4'b1010;

    // Bit slot counter values: 8 data rises, then the acknowledge clock.
    localparam logic [3:0] SLOT_ACK  = 4'd8;
    localparam logic [3:0] SLOT_DONE = 4'd9;

    // Transfer phase of the controller.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_AHI,
        PH_ALO,
        PH_WR,
        PH_RD
    } phase_e;

endpackage

// File: rtl/sermem_i2c_sync.sv
// Module: bus line synchronizer and condition detector.
// Brings the clock and data lines into the system clock domain through
// STAGES flops. It reports clock edges and START/STOP on the synchronized
// copies. Assumes the system clock is several times faster than the bus.
module sermem_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = STAGES + 1;

    logic [1:0] stg [DEPTH];

    // First stage captures the raw lines; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= 2'b11;
        else        stg[0] <= {sda_i, scl_i};
    end

    genvar k;
    generate
        for (k = 1; k < DEPTH; k++) begin : g_stage
            // Further synchronizer / history stages.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[k] <= 2'b11;
                else        stg[k] <= stg[k-1];
            end
        end
    endgenerate

    logic scl_q, sda_q;
    assign scl_s = stg[STAGES-1][0];
    assign sda_s = stg[STAGES-1][1];
    assign scl_q = stg[STAGES][0];
    assign sda_q = stg[STAGES][1];

    // Edge and bus condition decode on the synchronized copies.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/sermem_i2c_addr.sv
// Module: current address counter.
// Loads a new address, advances inside the page for writes and over the
// whole range for reads. Assumes load and increments never coincide.
module sermem_i2c_addr #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              inc_page,
    input  logic              inc_lin,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] nxt_page;
    logic [ADDR_W-1:0] nxt_lin;

    assign nxt_lin = addr + 1'b1;

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            assign nxt_page = nxt_lin;
        end else begin : g_paged
            assign nxt_page = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};

            // Page writes never move the row bits (R5).
            assert_page_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $past(inc_page) && !$past(ld) |-> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
        end
    endgenerate

    // Address register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr <= '0;
        else if (ld)       addr <= ld_val;
        else if (inc_page) addr <= nxt_page;
        else if (inc_lin)  addr <= nxt_lin;
    end

endmodule

// File: rtl/sermem_i2c_ctrl.sv
// Module: transfer controller.
// Counts bit slots, shifts bytes in and out, decodes the select byte,
// collects the address, decides ACK/NACK and issues memory strobes.
// Assumes mem_rdata is valid for the current address well before the
// byte it feeds starts, and that sda_oe is only changed on clock falls.
module sermem_i2c_ctrl
    import sermem_i2c_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap_i,
    input  logic              wc_i,
    input  logic              mem_busy,
    input  logic [7:0]        mem_rdata,
    output logic              sda_oe,
    output logic              ld,
    output logic [ADDR_W-1:0] ld_val,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              rd_inc,
    output logic              commit_req
);
    phase_e      ph;
    logic [3:0]  slot;
    logic [7:0]  shin;
    logic [7:0]  shout;
    logic [7:0]  hi_byte;
    logic        first_rd;
    logic        mst_ack;
    logic        wrote;
    logic [15:0] full_addr;
    logic        sel_hit;

    assign full_addr = {hi_byte, shin};
    assign sel_hit   = (shin[7:4] == SEL_TYPE) && (shin[3:1] == strap_i);

    // Main sequencer: bus conditions first, then bit slot handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph         <= PH_IDLE;
            slot       <= '0;
            shin       <= '0;
            shout      <= '0;
            hi_byte    <= '0;
            first_rd   <= 1'b0;
            mst_ack    <= 1'b0;
            wrote      <= 1'b0;
            sda_oe     <= 1'b0;
            ld         <= 1'b0;
            ld_val     <= '0;
            wr_en      <= 1'b0;
            wr_data    <= '0;
            rd_inc     <= 1'b0;
            commit_req <= 1'b0;
        end else begin
            ld         <= 1'b0;
            wr_en      <= 1'b0;
            rd_inc     <= 1'b0;
            commit_req <= 1'b0;
            if (mem_busy) begin
                ph     <= PH_IDLE;
                sda_oe <= 1'b0;
                slot   <= '0;
                wrote  <= 1'b0;
            end else if (start_det) begin
                ph     <= PH_SEL;
                slot   <= '0;
                sda_oe <= 1'b0;
                wrote  <= 1'b0;
            end else if (stop_det) begin
                // The STOP's own clock rise lands in slot 1 after an ACK.
                if (ph == PH_WR && slot == 4'd1 && wrote)
                    commit_req <= 1'b1;
                ph     <= PH_IDLE;
                slot   <= '0;
                sda_oe <= 1'b0;
                wrote  <= 1'b0;
            end else if (ph != PH_IDLE) begin
                if (scl_rise) begin
                    if (slot < SLOT_ACK) begin
                        shin <= {shin[6:0], sda_s};
                        slot <= slot + 1'b1;
                    end else if (slot == SLOT_ACK) begin
                        slot    <= SLOT_DONE;
                        mst_ack <= ~sda_s;
                    end
                end else if (scl_fall) begin
                    if (slot == SLOT_ACK) begin
                        unique case (ph)
                            PH_SEL: begin
                                if (sel_hit) begin
                                    sda_oe <= 1'b1;
                                    if (shin[0]) begin
                                        ph       <= PH_RD;
                                        first_rd <= 1'b1;
                                    end else begin
                                        ph <= PH_AHI;
                                    end
                                end else begin
                                    ph <= PH_IDLE;
                                end
                            end
                            PH_AHI: begin
                                sda_oe  <= 1'b1;
                                hi_byte <= shin;
                                ph      <= PH_ALO;
                            end
                            PH_ALO: begin
                                sda_oe <= 1'b1;
                                ld     <= 1'b1;
                                ld_val <= full_addr[ADDR_W-1:0];
                                ph     <= PH_WR;
                            end
                            PH_WR: begin
                                if (!wc_i) begin
                                    sda_oe  <= 1'b1;
                                    wr_en   <= 1'b1;
                                    wr_data <= shin;
                                    wrote   <= 1'b1;
                                end
                            end
                            PH_RD: sda_oe <= 1'b0;
                            default: ph <= PH_IDLE;
                        endcase
                    end else if (slot == SLOT_DONE) begin
                        slot <= '0;
                        if (ph == PH_RD) begin
                            if (first_rd || mst_ack) begin
                                shout    <= mem_rdata;
                                sda_oe   <= ~mem_rdata[7];
                                rd_inc   <= 1'b1;
                                first_rd <= 1'b0;
                            end else begin
                                ph     <= PH_IDLE;
                                sda_oe <= 1'b0;
                            end
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end else if (ph == PH_RD && slot != 4'd0) begin
                        sda_oe <= ~shout[6];
                        shout  <= {shout[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // Write strobes are single-cycle pulses (R4).
    assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // No write strobe follows a cycle with write control high (R6).
    assert_wc_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(wc_i));

    // A commit request only follows a detected STOP (R7).
    assert_commit_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> $past(stop_det));

    // Silent while the memory is busy (R11).
    assert_busy_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_busy) |-> !sda_oe);

endmodule

// File: rtl/sermem_i2c_slave.sv
// Module: serial memory two-wire slave engine (top).
// Joins the line synchronizer, the transfer controller and the address
// counter. Assumes clk is at least about 8x the bus clock rate and that
// ADDR_W is at most 16.
module sermem_i2c_slave #(
    parameter int ADDR_W    = 15,
    parameter int PAGE_W    = 6,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap_i,
    input  logic              wc_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata,
    output logic              commit_req,
    input  logic              mem_busy
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              ld, rd_inc;
    logic [ADDR_W-1:0] ld_val;

    sermem_i2c_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    sermem_i2c_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_s      (sda_s),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .strap_i    (strap_i),
        .wc_i       (wc_i),
        .mem_busy   (mem_busy),
        .mem_rdata  (mem_rdata),
        .sda_oe     (sda_oe),
        .ld         (ld),
        .ld_val     (ld_val),
        .wr_en      (mem_we),
        .wr_data    (mem_wdata),
        .rd_inc     (rd_inc),
        .commit_req (commit_req)
    );

    sermem_i2c_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ld),
        .ld_val   (ld_val),
        .inc_page (mem_we),
        .inc_lin  (rd_inc),
        .addr     (mem_addr)
    );

    // The open-drain enable only moves while the bus clock is low (R13).
    assert_oe_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

endmodule

// File: tb/sermem_i2c_slave_tb.sv
module sermem_i2c_slave_tb;
    localparam int AW = 8;
    localparam int PW = 4;
    localparam int H  = 8;
    localparam logic [7:0] SELW = 8'hAA; // 1010 101 0, strap 101
    localparam logic [7:0] SELR = 8'hAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, wc = 1'b0;
    logic sda_oe, mem_we, commit_req, mem_busy;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic sda_line;
    logic [7:0] mem [1 << AW];
    int busy_cnt = 0;
    int checks = 0, errors = 0, commits = 0;
    bit done = 0;
    logic [15:0] exp_q [$];

    always #10 clk = ~clk;
    assign sda_line  = m_sda & ~sda_oe;
    assign mem_rdata = mem[mem_addr];
    assign mem_busy  = busy_cnt != 0;

    sermem_i2c_slave #(.ADDR_W(AW), .PAGE_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_i(3'b101), .wc_i(wc), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .commit_req(commit_req), .mem_busy(mem_busy));

    initial for (int i = 0; i < (1 << AW); i++) mem[i] = 8'(i) ^ 8'h5A;

    // Memory model and write-cycle timer.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (commit_req) busy_cnt <= 600;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected writes, counts commits.
    always @(negedge clk) if (rst_n) begin
        if (commit_req) commits++;
        if (mem_we) begin
            if (exp_q.size() == 0) check("R6 unexpected write", {mem_addr, mem_wdata}, 0);
            else check("R4/R5 write", {mem_addr, mem_wdata}, exp_q.pop_front());
        end
    end

    task automatic hw(); repeat (H) @(negedge clk); endtask
    task automatic do_start(); m_sda = 1; hw(); m_scl = 1; hw(); m_sda = 0; hw(); m_scl = 0; hw(); endtask
    task automatic do_stop(); m_sda = 0; hw(); m_scl = 1; hw(); m_sda = 1; hw(); endtask
    task automatic put_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            repeat (2) @(negedge clk); m_sda = v[7-i]; hw(); m_scl = 1; hw(); m_scl = 0;
        end
    endtask
    task automatic send(input logic [7:0] v, input bit exp_ack, input string req);
        logic a;
        put_bits(v, 8);
        repeat (2) @(negedge clk); m_sda = 1; hw(); m_scl = 1;
        repeat (H/2) @(negedge clk); a = ~sda_line; repeat (H/2) @(negedge clk); m_scl = 0;
        check(req, a, exp_ack);
    endtask
    task automatic recv(input bit ack, input logic [7:0] exp, input string req);
        logic [7:0] v = 0;
        m_sda = 1;
        for (int i = 0; i < 8; i++) begin
            hw(); m_scl = 1; repeat (H/2) @(negedge clk); v = {v[6:0], sda_line};
            repeat (H/2) @(negedge clk); m_scl = 0;
        end
        repeat (2) @(negedge clk); m_sda = ~ack; hw(); m_scl = 1; hw(); m_scl = 0;
        repeat (2) @(negedge clk); m_sda = 1;
        check(req, v, exp);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R1 oe", sda_oe, 0); check("R1 we", mem_we, 0); check("R1 commit", commit_req, 0);
        rst_n = 1; repeat (5) @(negedge clk);
        // R2 mismatches
        do_start(); send(8'hA4, 0, "R2 strap mismatch"); send(SELW, 0, "R2 ignored until START"); do_stop();
        do_start(); send(8'hBA, 0, "R2 type mismatch"); do_stop();
        // R3/R4 byte write
        do_start(); send(SELW, 1, "R2 select ack"); send(8'h12, 1, "R3 addr hi"); send(8'h34, 1, "R3 addr lo");
        exp_q.push_back({8'h34, 8'hC3}); send(8'hC3, 1, "R4 data ack"); do_stop();
        // R11 polling while busy
        do_start(); send(SELW, 0, "R11 busy nack"); do_stop();
        wait (!mem_busy); repeat (5) @(negedge clk);
        do_start(); send(SELW, 1, "R11 ready ack"); send(8'h00, 1, "R3 hi"); send(8'h3E, 1, "R3 lo");
        exp_q.push_back({8'h3E, 8'h11}); exp_q.push_back({8'h3F, 8'h22}); exp_q.push_back({8'h30, 8'h33});
        send(8'h11, 1, "R4 page"); send(8'h22, 1, "R4 page"); send(8'h33, 1, "R5 page wrap"); do_stop();
        check("R7 commits", commits, 2);
        wait (!mem_busy); repeat (5) @(negedge clk);
        // R8/R9/R10 random + sequential read
        do_start(); send(SELW, 1, "R8 dummy sel"); send(8'h00, 1, "R8 hi"); send(8'h3E, 1, "R8 lo");
        do_start(); send(SELR, 1, "R8 read sel");
        recv(1, 8'h11, "R8 random read"); recv(1, 8'h22, "R9 sequential"); recv(0, 8'h40 ^ 8'h5A, "R9 linear across page");
        recv(0, 8'hFF, "R10 released after NACK"); do_stop();
        do_start(); send(SELR, 1, "R9 cur sel"); recv(0, 8'h41 ^ 8'h5A, "R9 current address"); do_stop();
        // R12 read wrap with wc high, R6 address acked under wc
        wc = 1;
        do_start(); send(SELW, 1, "R6 sel"); send(8'h00, 1, "R6 hi"); send(8'hFF, 1, "R6 lo");
        do_start(); send(SELR, 1, "R12 sel"); recv(1, 8'hA5, "R12 read under wc"); recv(0, 8'h5A, "R9 wrap to 0"); do_stop();
        do_start(); send(SELW, 1, "R6 sel"); send(8'h00, 1, "R6 hi"); send(8'h50, 1, "R6 lo");
        send(8'h77, 0, "R6 data nack"); do_stop();
        do_start(); send(SELR, 1, "R6 sel"); recv(0, 8'h50 ^ 8'h5A, "R6 unmodified, address held"); do_stop();
        wc = 0;
        // R7 no commit cases
        do_start(); send(SELW, 1, "R7 sel"); send(8'h00, 1, "R7 hi"); send(8'h61, 1, "R7 lo"); put_bits(8'hEE, 4); do_stop();
        do_start(); send(SELW, 1, "R7 sel"); send(8'h00, 1, "R7 hi"); send(8'h60, 1, "R7 lo"); do_stop();
        repeat (20) @(negedge clk);
        check("R7 no extra commit", commits, 2); check("R7 busy idle", mem_busy, 0);
        // R14 abort mid byte
        do_start(); put_bits(8'hA0, 4); m_sda = 1; hw(); m_scl = 1; hw(); m_sda = 0; hw(); m_scl = 0; hw();
        send(SELR, 1, "R14 select after abort"); recv(0, 8'h60 ^ 8'h5A, "R14 read after abort"); do_stop();
        check("R4 queue drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule